// File: doc/BRIEF.md
# Dual-Prescaler Channel Tick Generator

This block turns one input clock into five independent count-enable strobes, one per timer channel. Two free-running prescalers sit at the front. The lower two channels share the first prescaler, and the upper three share the second. After its prescaler, each channel has its own power-of-two post-divider. The resulting strobe is one clock wide and is meant to advance a down-counter kept outside the block.

Software sets two configuration words, and the block reads them as plain inputs. The prescaler word holds one 8-bit limit per prescaler. The selector word holds one 4-bit divider code per channel. The tick period of a channel is (limit+1)·2^d input clocks, where d is the divider code after clamping. Either word may change at any time without a reset. A new prescaler limit is taken in only when that prescaler wraps. A new divider code applies from the next prescaler strobe.

Top module: `chtick_top`

## Requirements
- R1: While `rst_n` is low, every bit of `tick_o` is 0 on the clock after each edge at which reset was sampled.
- R2: Prescaler A takes its limit from `cfg_pre_i[7:0]` and drives channels 0 and 1. Prescaler B takes its limit from `cfg_pre_i[15:8]` and drives channels 2, 3 and 4. Bits `cfg_pre_i[31:16]` have no effect.
- R3: A prescaler with limit P emits one strobe every P+1 input clocks.
- R4: Channel n reads divider code d from `cfg_sel_i[4n+3:4n]` and emits one tick per 2^d strobes of its prescaler. Bits `cfg_sel_i[31:20]` have no effect.
- R5: A divider code above 4 acts exactly as code 4, which gives division by 16.
- R6: After reset is released with limit P and code d held, channel n is first high on the clock after the ((P+1)·2^d)-th rising edge that samples `rst_n` high.
- R7: With steady configuration, ticks of a channel are spaced exactly (P+1)·2^min(d,4) clocks apart. Each tick is one clock wide when that spacing exceeds 1, and `tick_o` is high on every clock when the spacing is 1.
- R8: A change to either configuration word takes effect without a reset. A prescaler keeps its old limit until its next wrap strobe, and then loads the current field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that all prescalers count |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pre_i | input | 32 | Prescaler limit word: A in [7:0], B in [15:8] |
| cfg_sel_i | input | 32 | Divider code word: 4 bits per channel at [4n+3:4n] |
| tick_o | output | 5 | One-clock tick strobe per channel |

## Verification
The assertions check the following on every cycle:
- a channel ticks only in the cycle right after its own prescaler strobed;
- after a wrap, a prescaler loads the field belonging to it;
- a prescaler's limit never moves between wraps;
- the spacing of strobes follows the limit just loaded;
- the outputs are quiet during reset.

The exact tick spacing, the clamp of large codes, the first-tick time after reset and the settling after live configuration changes can only be shown by the bench's scenarios. The bench measures intervals at the ports under directed and random words, including stray upper bits.

// File: rtl/chtick_pkg.sv
// Package: shared constants and channel-to-prescaler mapping for the
// channel tick generator. Assumes exactly two prescaler groups.
package chtick_pkg;

    // number of prescaler groups feeding the channels
    localparam int unsigned NUM_GROUPS = 2;

    // Return the prescaler group index for a channel: channels below the
    // split point use group 0, the rest use group 1.
    function automatic int unsigned chan_group(input int unsigned ch,
                                               input int unsigned split);
        return (ch < split) ? 0 : 1;
    endfunction

    // Width needed to hold values 0..n (at least 1 bit).
    function automatic int unsigned width_for(input int unsigned n);
        int unsigned w;
        w = 1;
        while ((1 << w) <= n) w++;
        return w;
    endfunction

endpackage

// File: rtl/chtick_prescaler.sv
// Module: free-running prescaler. Counts input clocks from 0 up to a
// latched limit and asserts a combinational strobe in the terminal cycle.
// The limit input is sampled only on reset and at each wrap, so a new
// value never cuts a running period short.
// Assumes: limit_i is synchronous to clk.
module chtick_prescaler #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] limit_i,
    output logic             strobe_o,
    output logic [PRE_W-1:0] limit_o
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] lim_q;

    // terminal-count detect
    assign strobe_o = (cnt_q == lim_q);
    assign limit_o  = lim_q;

    // count up, wrap to zero at the terminal value and take a fresh limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= limit_i;
        end else if (strobe_o) begin
            cnt_q <= '0;
            lim_q <= limit_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/chtick_postdiv.sv
// Module: per-channel power-of-two post-divider. Counts prescaler strobes
// and emits a registered one-clock tick on every 2^d-th strobe, with the
// code d clamped to MAX_LOG. A code change applies at the next strobe;
// a counter already past the new terminal value wraps on that strobe.
// Assumes: strobe_i is a single-cycle pulse from the prescaler.
module chtick_postdiv
    import chtick_pkg::*;
#(
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned MAX_LOG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    localparam int unsigned CNT_W = (MAX_LOG > 0) ? MAX_LOG : 1;
    localparam int unsigned EFF_W = width_for(MAX_LOG);

    logic [EFF_W-1:0] eff_log;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] term;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic             tick_q;

    // clamp the selected code to the largest supported shift
    always_comb begin
        if (sel_i > SEL_W'(MAX_LOG))
            eff_log = EFF_W'(MAX_LOG);
        else
            eff_log = EFF_W'(sel_i);
    end

    // terminal strobe index 2^d - 1
    always_comb begin
        span = (CNT_W+1)'(1) << eff_log;
        term = CNT_W'(span - 1'b1);
    end

    // divider wraps on a strobe at or beyond the terminal index
    assign wrap = strobe_i && (cnt_q >= term);

    // count strobes and register the tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= wrap;
            if (strobe_i)
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/chtick_top.sv
// Module: channel tick generator top. Two prescalers, each fed by one
// byte of the prescaler word, drive NUM_CH post-dividers; channels below
// SPLIT use prescaler 0, the rest prescaler 1. Unused upper bits of both
// words are ignored.
// Assumes: configuration words are synchronous to clk.
module chtick_top
    import chtick_pkg::*;
#(
    parameter int unsigned NUM_CH  = 5,
    parameter int unsigned SPLIT   = 2,
    parameter int unsigned PRE_W   = 8,
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned MAX_LOG = 4,
    parameter int unsigned CFG_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_pre_i,
    input  logic [CFG_W-1:0]  cfg_sel_i,
    output logic [NUM_CH-1:0] tick_o
);

    localparam int unsigned PRE_BITS = NUM_GROUPS * PRE_W;
    localparam int unsigned SEL_BITS = NUM_CH * SEL_W;

    logic [NUM_GROUPS-1:0] pre_stb;
    logic [PRE_BITS-1:0]   pre_lim;
    logic                  unused_cfg_bits;

    // fold the ignored upper configuration bits into a sink
    assign unused_cfg_bits = ^{cfg_pre_i[CFG_W-1:PRE_BITS],
                               cfg_sel_i[CFG_W-1:SEL_BITS]};

    // one prescaler per group
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pre
        chtick_prescaler #(
            .PRE_W (PRE_W)
        ) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .limit_i  (cfg_pre_i[g*PRE_W +: PRE_W]),
            .strobe_o (pre_stb[g]),
            .limit_o  (pre_lim[g*PRE_W +: PRE_W])
        );
    end

    // one post-divider per channel, fed from its group's prescaler
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int unsigned GRP = chan_group(n, SPLIT);
        chtick_postdiv #(
            .SEL_W   (SEL_W),
            .MAX_LOG (MAX_LOG)
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_i (pre_stb[GRP]),
            .sel_i    (cfg_sel_i[n*SEL_W +: SEL_W]),
            .tick_o   (tick_o[n])
        );
    end

endmodule

// File: rtl/chtick_checker.sv
// Module: assertion checker for chtick_top, attached by bind below.
// Observes the ports and the prescaler strobes and limits.
module chtick_checker
    import chtick_pkg::*;
#(
    parameter int unsigned NUM_CH = 5,
    parameter int unsigned SPLIT  = 2,
    parameter int unsigned PRE_W  = 8,
    parameter int unsigned CFG_W  = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [CFG_W-1:0]            cfg_pre_i,
    input logic [NUM_CH-1:0]           tick_o,
    input logic [NUM_GROUPS-1:0]       pre_stb,
    input logic [NUM_GROUPS*PRE_W-1:0] pre_lim
);

    // outputs quiet during reset
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> tick_o == '0);  // R1

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        // limit only moves at a wrap
        AST_LIMIT_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            !pre_stb[g] |=> $stable(pre_lim[g*PRE_W +: PRE_W]));  // R8
        // the limit loaded at a wrap is this group's own field
        AST_LIMIT_FROM_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
            pre_stb[g] |=> pre_lim[g*PRE_W +: PRE_W] == $past(cfg_pre_i[g*PRE_W +: PRE_W]));  // R2
        // after a wrap the next strobe follows at once only for limit zero
        AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            pre_stb[g] |=> pre_stb[g] == (pre_lim[g*PRE_W +: PRE_W] == '0));  // R3
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        localparam int unsigned GRP = chan_group(n, SPLIT);
        // a tick always follows a strobe of the channel's own prescaler
        AST_TICK_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o[n] |-> $past(pre_stb[GRP]));  // R4
    end

endmodule

bind chtick_top chtick_checker #(
    .NUM_CH (NUM_CH),
    .SPLIT  (SPLIT),
    .PRE_W  (PRE_W),
    .CFG_W  (CFG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_pre_i (cfg_pre_i),
    .tick_o    (tick_o),
    .pre_stb   (pre_stb),
    .pre_lim   (pre_lim)
);

// File: tb/sim_chtick_top.sv
// Bench for chtick_top: directed corners plus seeded random words,
// tick spacing and first-tick times checked against bench functions.
module sim_chtick_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_pre = 32'h0000_0101;
    logic [31:0] cfg_sel = 32'h0000_0000;
    logic [4:0]  tick;

    int unsigned errors = 0;
    int unsigned checks = 0;
    int unsigned cyc = 0;

    int unsigned first_t [NCH];
    bit          got_first [NCH];
    int unsigned last_t [NCH];
    bit          seen_win [NCH];
    int unsigned win_ticks [NCH];
    int unsigned win_bad [NCH];
    int unsigned bad_gap [NCH];
    int unsigned exp_gap [NCH];
    bit          mon_on = 1'b0;
    int unsigned prev_max = 2;

    chtick_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_pre_i (cfg_pre),
        .cfg_sel_i (cfg_sel),
        .tick_o    (tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // rising edges since reset release
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // expected spacing of channel ch for the given words
    function automatic int unsigned exp_period(input logic [31:0] pw,
                                               input logic [31:0] sw,
                                               input int ch);
        int unsigned p;
        int unsigned d;
        p = (ch < 2) ? pw[7:0] : pw[15:8];
        d = (sw >> (4*ch)) & 4'hF;
        if (d > 4) d = 4;
        return (p + 1) << d;
    endfunction

    // tick monitor, sampling between edges
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                if (tick[c]) begin
                    if (!got_first[c]) begin
                        got_first[c] = 1'b1;
                        first_t[c]   = cyc;
                    end
                    if (mon_on) begin
                        if (seen_win[c] && (cyc - last_t[c]) != exp_gap[c]) begin
                            win_bad[c]++;
                            bad_gap[c] = cyc - last_t[c];
                        end
                        seen_win[c] = 1'b1;
                        last_t[c]   = cyc;
                        win_ticks[c]++;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reset with given words, then check quiet outputs and first ticks
    task automatic reset_run(input logic [31:0] pw, input logic [31:0] sw);
        int unsigned mx;
        @(negedge clk);
        rst_n   = 1'b0;
        cfg_pre = pw;
        cfg_sel = sw;
        for (int c = 0; c < NCH; c++) got_first[c] = 1'b0;
        wait_cycles(3);
        check(tick == '0, "R1 tick during reset", tick, 0);
        rst_n = 1'b1;
        mx = 0;
        for (int c = 0; c < NCH; c++)
            if (exp_period(pw, sw, c) > mx) mx = exp_period(pw, sw, c);
        wait_cycles(mx + 4);
        for (int c = 0; c < NCH; c++)
            check(got_first[c] && first_t[c] == exp_period(pw, sw, c),
                  $sformatf("R6 first tick ch%0d", c), first_t[c], exp_period(pw, sw, c));
        prev_max = mx;
    endtask

    // apply new words live, let them settle, then measure spacing
    task automatic measure(input logic [31:0] pw, input logic [31:0] sw, input string tag);
        int unsigned mx;
        @(negedge clk);
        cfg_pre = pw;
        cfg_sel = sw;
        mx = 0;
        for (int c = 0; c < NCH; c++)
            if (exp_period(pw, sw, c) > mx) mx = exp_period(pw, sw, c);
        wait_cycles(prev_max + 2*mx + 8);
        @(posedge clk); #1;
        for (int c = 0; c < NCH; c++) begin
            exp_gap[c]   = exp_period(pw, sw, c);
            seen_win[c]  = 1'b0;
            win_ticks[c] = 0;
            win_bad[c]   = 0;
            bad_gap[c]   = 0;
        end
        mon_on = 1'b1;
        wait_cycles(3*mx + 8);
        @(posedge clk); #1;
        mon_on = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            check(win_bad[c] == 0, $sformatf("%s R7 spacing ch%0d", tag, c),
                  bad_gap[c], exp_gap[c]);
            check(win_ticks[c] >= 3, $sformatf("%s R8 ticks present ch%0d", tag, c),
                  win_ticks[c], 3);
        end
        prev_max = mx;
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] pw;
        logic [31:0] sw;
        void'($urandom(32'd4813));
        // R1, R6: default words give spacing 2 on every channel
        reset_run(32'h0000_0101, 32'h0);
        // R6: distinct limits and codes at release
        reset_run(32'h0000_0302, 32'h0004_2301);
        // R7: spacing 1 gives a tick on every cycle
        measure(32'h0000_0000, 32'h0, "R7 period-one");
        for (int k = 0; k < 6; k++) begin
            checks++;
            if (tick != 5'b11111) begin
                errors++;
                $display("FAIL R7 constant tick actual=%0d expected=%0d", tick, 31);
            end
            @(negedge clk);
        end
        // R2, R3: groups differ, codes zero, stray upper bits set
        measure(32'hA5C3_0704, 32'hFFF0_0000, "R2 R3 group split");
        // R4: each channel its own code
        measure(32'h0000_0101, 32'h0004_3210, "R4 per-channel codes");
        // R5: codes above 4 clamp to 16
        measure(32'h0000_0203, 32'h000F_9587, "R5 clamp");
        // R8: live change of the limit only
        measure(32'h0000_0506, 32'h0004_3210, "R8 live limit change");
        // R3: full-range limit with largest division
        measure(32'h0000_FFFF, 32'h0004_4444, "R3 max limit");
        // random words, including stray upper bits and clamped codes
        for (int k = 0; k < 12; k++) begin
            pw = {$urandom() % 65536, 4'h0, 4'($urandom() % 16), 4'h0, 4'($urandom() % 16)};
            sw = $urandom();
            for (int c = 0; c < NCH; c++)
                sw[4*c +: 4] = 4'($urandom() % 7);
            measure(pw, sw, $sformatf("R2 R4 R5 random%0d", k));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule